// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for each of the two ALU operands of the instruction sitting in the execute stage, where that operand should come from. It compares the two source register numbers of that instruction with the destination register numbers held by the two younger pipeline registers, one at the memory stage and one at the writeback stage. It then drives one 2-bit mux select per operand. A select can pick the value read from the register file, the ALU result waiting at the memory stage, or the value waiting at the writeback stage.

A later stage counts as a forwarding source only while its register-write flag is set and its destination is not register zero. When both later stages hold the register an operand needs, the memory stage wins, because it holds the more recent write in program order. The unit has no state, clock or reset. Its outputs follow its inputs within the same time step. The load-use stall is handled elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage matches a source, that operand's select is 00, which chooses the register-file value.
- R2: When the memory stage has its write flag set and its nonzero destination equals the source, the select is 10.
- R3: When the writeback stage has its write flag set and its nonzero destination equals the source, and the memory stage does not match, the select is 01.
- R4: When both later stages match the same source, the select is 10, so the memory stage has priority.
- R5: A destination of register 0 never causes a forward from either stage, even with the write flag set.
- R6: A stage whose write flag is clear never causes a forward, even when its destination equals the source.
- R7: Operand A's select depends only on the rs source and operand B's select depends only on the rt source. Both are computed independently from the same stage fields.
- R8: The selects are combinational and settle after an input change without any clock edge.
- R9: A select never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs | input | 5 | First source register number of the instruction in execute |
| ex_rt | input | 5 | Second source register number of the instruction in execute |
| exmem_rd | input | 5 | Destination register number held at the memory stage |
| exmem_wr | input | 1 | Register-write flag held at the memory stage |
| memwb_rd | input | 5 | Destination register number held at the writeback stage |
| memwb_wr | input | 1 | Register-write flag held at the writeback stage |
| fwd_sel_a | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 writeback stage |
| fwd_sel_b | output | 2 | Operand B select, with the same encoding as operand A |

## Verification
The assertions assume that every input has a defined 0/1 value whenever they are evaluated. They also assume that a stage's destination number is meaningful only together with its own write flag, so they make no claim about a stage whose flag is clear. The stimulus drives only known values, and each vector is held for a full time step before the selects are sampled. The vector table and the sweep both include cases where a cleared write flag or register zero sits next to a matching register number. This exercises the guards without ever leaving the inputs undefined.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand source selects: the encoding is fixed because the operand
  // multiplexers in the execute stage decode it.
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;

  // Priority choice between the two later stages: the nearer one wins.
  function automatic fwd_sel_e pick_source(input logic hit_mem, input logic hit_wb);
    fwd_sel_e s;
    s = SEL_RF;
    if (hit_wb)  s = SEL_WB;
    if (hit_mem) s = SEL_MEM;
    return s;
  endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src,
  output logic             hit,
  output logic             dst_live
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  function automatic logic same_reg(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
    return (a == b);
  endfunction

  assign dst_live = wr_en && (dst != ZERO_REG);
  assign hit      = dst_live && same_reg(dst, src);

  always_comb begin
    // R5: register zero is never a forwarding source
    a_r5_zero_dst_no_hit: assert (!(hit && dst == ZERO_REG))
      else $error("match hit on register zero");
    // R6: a stage that does not write is never a forwarding source
    a_r6_no_wr_no_hit: assert (!(hit && !wr_en))
      else $error("match hit without write flag");
  end

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
(
  input  logic       hit_mem,
  input  logic       hit_wb,
  output logic [1:0] sel
);

  fwd_sel_e choice;

  always_comb choice = pick_source(hit_mem, hit_wb);
  assign sel = choice;

  always_comb begin
    // R4: memory stage wins whenever it matches
    a_r4_nearest_wins: assert (!hit_mem || sel == 2'b10)
      else $error("memory stage hit not selected");
    // R3: writeback chosen only when memory stage misses
    a_r3_wb_when_alone: assert (!(hit_wb && !hit_mem) || sel == 2'b01)
      else $error("writeback hit not selected");
    // R1: no hit falls back to the register file
    a_r1_default_rf: assert (hit_mem || hit_wb || sel == 2'b00)
      else $error("select not register file on miss");
    // R9: the unused code never appears
    a_r9_no_code3: assert (sel != 2'b11)
      else $error("illegal select 11");
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] exmem_rd,
  input  logic             exmem_wr,
  input  logic [REG_W-1:0] memwb_rd,
  input  logic             memwb_wr,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b
);

  localparam int unsigned N_OPS = 2;

  logic [REG_W-1:0] src     [N_OPS];
  logic [1:0]       sel     [N_OPS];
  logic             hit_mem [N_OPS];
  logic             hit_wb  [N_OPS];
  logic             live_mem[N_OPS];
  logic             live_wb [N_OPS];

  // R7: operand 0 uses rs, operand 1 uses rt
  assign src[0] = ex_rs;
  assign src[1] = ex_rt;

  for (genvar op = 0; op < N_OPS; op++) begin : g_op
    fwd_match #(.REG_W(REG_W)) u_mem (
      .wr_en(exmem_wr), .dst(exmem_rd), .src(src[op]),
      .hit(hit_mem[op]), .dst_live(live_mem[op])
    );
    fwd_match #(.REG_W(REG_W)) u_wb (
      .wr_en(memwb_wr), .dst(memwb_rd), .src(src[op]),
      .hit(hit_wb[op]), .dst_live(live_wb[op])
    );
    fwd_pick u_pick (
      .hit_mem(hit_mem[op]), .hit_wb(hit_wb[op]), .sel(sel[op])
    );

    always_comb begin
      // R2: a live memory-stage destination equal to the source forwards from it
      a_r2_mem_forward: assert (!(live_mem[op] && exmem_rd == src[op]) || sel[op] == 2'b10)
        else $error("memory stage forward missing");
      // R5 / R6: with neither stage live, nothing forwards
      a_r5_dead_stages_rf: assert (live_mem[op] || live_wb[op] || sel[op] == 2'b00)
        else $error("forward from dead stage");
    end
  end

  assign fwd_sel_a = sel[0];
  assign fwd_sel_b = sel[1];

endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0] ex_rs, ex_rt, exmem_rd, memwb_rd;
  logic       exmem_wr, memwb_wr;
  logic [1:0] fwd_sel_a, fwd_sel_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  fwd_unit dut_i (
    .ex_rs(ex_rs), .ex_rt(ex_rt),
    .exmem_rd(exmem_rd), .exmem_wr(exmem_wr),
    .memwb_rd(memwb_rd), .memwb_wr(memwb_wr),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
  );

  // Vector: rs, rt, mem_rd, mem_wr, wb_rd, wb_wr, expA, expB
  localparam int NVEC = 14;
  localparam logic [25:0] VEC [NVEC] = '{
    {5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 2'b00, 2'b00},  // R1 no match
    {5'd2, 5'd3, 5'd2, 1'b1, 5'd9, 1'b0, 2'b10, 2'b00},  // R2 A from mem
    {5'd3, 5'd2, 5'd2, 1'b1, 5'd0, 1'b0, 2'b00, 2'b10},  // R2 B from mem
    {5'd7, 5'd8, 5'd1, 1'b1, 5'd7, 1'b1, 2'b01, 2'b00},  // R3 A from wb
    {5'd5, 5'd6, 5'd1, 1'b0, 5'd6, 1'b1, 2'b00, 2'b01},  // R3 B from wb
    {5'd4, 5'd4, 5'd4, 1'b1, 5'd4, 1'b1, 2'b10, 2'b10},  // R4 both match
    {5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 2'b00, 2'b00},  // R5 zero reg
    {5'd0, 5'd3, 5'd0, 1'b1, 5'd3, 1'b1, 2'b00, 2'b01},  // R5 zero mem, wb live
    {5'd9, 5'd9, 5'd9, 1'b0, 5'd9, 1'b0, 2'b00, 2'b00},  // R6 no write flags
    {5'd9, 5'd9, 5'd9, 1'b0, 5'd9, 1'b1, 2'b01, 2'b01},  // R6 mem flag clear
    {5'd10,5'd11,5'd11,1'b1, 5'd10,1'b1, 2'b01, 2'b10},  // R7 independent
    {5'd31,5'd30,5'd31,1'b1, 5'd30,1'b1, 2'b10, 2'b01},  // R7 top registers
    {5'd12,5'd12,5'd12,1'b1, 5'd0, 1'b1, 2'b10, 2'b10},  // R4 wb zero
    {5'd1, 5'd1, 5'd2, 1'b1, 5'd1, 1'b1, 2'b01, 2'b01}   // R3 both ops wb
  };

  // Independent model: the guards are checked first, then the nearer stage.
  function automatic logic [1:0] model_sel(input logic [4:0] s,
      input logic [4:0] mrd, input logic mwr, input logic [4:0] wrd, input logic wwr);
    logic mem_ok, wb_ok;
    mem_ok = mwr && (mrd != 5'd0) && (mrd == s);
    wb_ok  = wwr && (wrd != 5'd0) && (wrd == s);
    if (mem_ok)     return 2'b10;
    else if (wb_ok) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_for(input logic [1:0] e, input logic mem_match, input logic wb_match);
    if (e == 2'b10 && wb_match) return "R4";
    if (e == 2'b10)             return "R2";
    if (e == 2'b01)             return "R3";
    if (mem_match || wb_match)  return "R5/R6";
    return "R1";
  endfunction

  task automatic drive(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] mrd,
                       input logic mwr, input logic [4:0] wrd, input logic wwr);
    ex_rs = rs; ex_rt = rt; exmem_rd = mrd; exmem_wr = mwr; memwb_rd = wrd; memwb_wr = wwr;
    #1;
  endtask

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (rs=%0d rt=%0d mrd=%0d mwr=%b wrd=%0d wwr=%b)",
               tag, act, exp, ex_rs, ex_rt, exmem_rd, exmem_wr, memwb_rd, memwb_wr);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
    @(negedge clk);
    check("R1 idle A", fwd_sel_a, 2'b00);
    check("R1 idle B", fwd_sel_b, 2'b00);

    for (int i = 0; i < NVEC; i++) begin
      logic [25:0] v;
      v = VEC[i];
      drive(v[25:21], v[20:16], v[15:11], v[10], v[9:5], v[4]);
      check($sformatf("table %0d A", i), fwd_sel_a, v[3:2]);
      check($sformatf("table %0d B", i), fwd_sel_b, v[1:0]);
    end

    // R8: selects follow an input change with no clock edge in between
    @(negedge clk);
    drive(5'd6, 5'd7, 5'd6, 1'b1, 5'd7, 1'b1);
    check("R8 settle A", fwd_sel_a, 2'b10);
    check("R8 settle B", fwd_sel_b, 2'b01);
    exmem_wr = 1'b0; #1;
    check("R8 flag drop A", fwd_sel_a, 2'b00);
    check("R8 flag drop B", fwd_sel_b, 2'b01);

    // Sweep small register numbers and all flag combinations against the model
    for (int rs = 0; rs < 4; rs++)
      for (int rt = 0; rt < 4; rt++)
        for (int m = 0; m < 4; m++)
          for (int w = 0; w < 4; w++)
            for (int f = 0; f < 4; f++) begin
              logic [1:0] ea, eb;
              drive(rs[4:0], rt[4:0], m[4:0], f[0], w[4:0], f[1]);
              ea = model_sel(rs[4:0], m[4:0], f[0], w[4:0], f[1]);
              eb = model_sel(rt[4:0], m[4:0], f[0], w[4:0], f[1]);
              check({tag_for(ea, m == rs, w == rs), " R7 sweep A"}, fwd_sel_a, ea);
              check({tag_for(eb, m == rt, w == rt), " R7 sweep B"}, fwd_sel_b, eb);
              if (fwd_sel_a == 2'b11 || fwd_sel_b == 2'b11) check("R9 code 11", 2'b11, 2'b00);
            end

    @(negedge clk);
    finish_run();
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    finish_run();
  end

endmodule